// File: doc/BRIEF.md
# Per-Bit Access-Policy Control Register

This block is one control/status register of a memory-mapped peripheral. Every bit carries its own access policy, fixed at elaboration by mask parameters. A bit can be freely writable, read-only, cleared by writing one, settable-only, clearable-only, hidden on read (write-only), or cleared by a read. A per-bit write-enable mask sent with each write narrows which bits the access may touch. A hardware-side input sets status bits directly, and the whole stored word is exposed to the surrounding logic.

Separate masks name the bit patterns that are illegal to write and the patterns that request features the block does not have. A write that matches one of these masks raises a one-cycle flag, and the write is still applied. A parameter can also mark the register as undefined. In that case every access is flagged as an error, writes and reads leave the storage untouched, and reads return zero.

Top module: `bitpol_reg`

## Requirements
- R1: Reset (rstN low) loads RESET_VAL into storage, and both flag outputs are low after reset.
- R2: A write changes no bit whose wrEn bit is 0, except for the write-one-to-clear rule in R5.
- R3: Bits in RO_MASK keep their value on every write. Only hwSet can change them.
- R4: Bits in SET_ONLY_MASK can be written to 1 but never to 0. Bits in CLR_ONLY_MASK can be written to 0 but never to 1.
- R5: A bit in W1C_MASK is cleared when it is written with 1, whatever its wrEn bit, and is unchanged when written with 0.
- R6: While rdStb is high, rdData shows the value from before the read. On that clock edge, every bit in COR_MASK is cleared in storage.
- R7: Bits in WO_MASK read back as their RESET_VAL bit, whatever is stored. regValue shows the true stored value.
- R8: hwSet ORs into storage on the same edge. A hwSet bit wins over a software clear (W1C write or clear-on-read) of that bit on the same edge.
- R9: errPulse is high for exactly the one cycle after a write edge in which wrData has a 1 in ERR_ON1_MASK or a 0 in ERR_ON0_MASK. The write still takes effect.
- R10: unimpPulse is high for exactly the one cycle after a write edge in which wrData has a 1 in UNIMP_ON1_MASK or a 0 in UNIMP_ON0_MASK. The write still takes effect.
- R11: With UNDEFINED=1, storage stays at RESET_VAL, rdData is zero, and every read or write raises errPulse for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | Bus write strobe |
| wrData | input | WIDTH | Bus write data |
| wrEn | input | WIDTH | Per-bit write enable |
| rdStb | input | 1 | Bus read strobe |
| rdData | output | WIDTH | Read data, combinational from storage |
| hwSet | input | WIDTH | Hardware status set vector |
| regValue | output | WIDTH | Raw stored value |
| errPulse | output | 1 | One-cycle illegal-access flag |
| unimpPulse | output | 1 | One-cycle unimplemented-feature flag |

## Verification
A wrong policy decision in the next-state logic appears on regValue at the first negative clock edge after the write or read that caused it. The read-data path is checked during the read strobe, before the edge, so a read mask that is wrong, or a clear that lands too early, shows up in the same cycle. The flag outputs are compared in the cycle after each access, and again in the idle cycle that follows, so a flag that is missing, too wide or stuck is caught within two cycles.

// File: rtl/bitpol_pkg.sv
package bitpol_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } polCtrl_t;
endpackage

// File: rtl/bitpol_ctrl.sv
module bitpol_ctrl
  import bitpol_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] ERR_ON1_MASK = '0,
  parameter logic [WIDTH-1:0] ERR_ON0_MASK = '0,
  parameter logic [WIDTH-1:0] UNIMP_ON1_MASK = '0,
  parameter logic [WIDTH-1:0] UNIMP_ON0_MASK = '0,
  parameter bit UNDEFINED = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrStb,
  input  logic rdStb,
  input  logic [WIDTH-1:0] wrData,
  output polCtrl_t ctrl,
  output logic errPulse,
  output logic unimpPulse
);
  logic errHit, unimpHit;

  generate
    if (UNDEFINED) begin : gUndef
      assign ctrl.doWrite = 1'b0;
      assign ctrl.doRead  = 1'b0;
      assign errHit   = wrStb | rdStb;
      assign unimpHit = 1'b0;
    end else begin : gDef
      assign ctrl.doWrite = wrStb;
      assign ctrl.doRead  = rdStb;
      assign errHit   = wrStb & (|(wrData & ERR_ON1_MASK) | |(~wrData & ERR_ON0_MASK));
      assign unimpHit = wrStb & (|(wrData & UNIMP_ON1_MASK) | |(~wrData & UNIMP_ON0_MASK));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse   <= 1'b0;
      unimpPulse <= 1'b0;
    end else begin
      errPulse   <= errHit;
      unimpPulse <= unimpHit;
    end
  end

  // R9: an error flag only follows an access
  assert_err_follows_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(wrStb | (UNDEFINED & rdStb)));
  // R10: an unimplemented flag only follows a write
  assert_unimp_follows_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    unimpPulse |-> $past(wrStb));
endmodule

// File: rtl/bitpol_dp.sv
module bitpol_dp
  import bitpol_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  parameter logic [WIDTH-1:0] RO_MASK = '0,
  parameter logic [WIDTH-1:0] W1C_MASK = '0,
  parameter logic [WIDTH-1:0] SET_ONLY_MASK = '0,
  parameter logic [WIDTH-1:0] CLR_ONLY_MASK = '0,
  parameter logic [WIDTH-1:0] WO_MASK = '0,
  parameter logic [WIDTH-1:0] COR_MASK = '0,
  parameter bit UNDEFINED = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  polCtrl_t ctrl,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] wrEn,
  input  logic [WIDTH-1:0] hwSet,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] regValue
);
  localparam logic [WIDTH-1:0] FIXED_MASK = RO_MASK | W1C_MASK;

  logic [WIDTH-1:0] store, afterWr, afterRd, nextStore;
  logic [WIDTH-1:0] blockZero, blockOne;

  always_comb begin
    blockZero = FIXED_MASK | SET_ONLY_MASK | ~wrEn;
    blockOne  = FIXED_MASK | CLR_ONLY_MASK | ~wrEn;
    afterWr   = store;
    if (ctrl.doWrite) begin
      afterWr = (wrData & ~blockOne) | (store & blockOne & wrData)
              | (store & blockZero & ~wrData);
      afterWr = afterWr & ~(wrData & W1C_MASK);
    end
    afterRd = ctrl.doRead ? (afterWr & ~COR_MASK) : afterWr;
  end

  generate
    if (UNDEFINED) begin : gUndef
      assign nextStore = RESET_VAL;
      assign rdData    = '0;
    end else begin : gDef
      assign nextStore = afterRd | hwSet;
      assign rdData    = (store & ~WO_MASK) | (RESET_VAL & WO_MASK);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) store <= RESET_VAL;
    else       store <= nextStore;
  end

  assign regValue = store;

  // R8: a hardware set is never lost
  assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN || UNDEFINED)
    1'b1 |=> ((store & $past(hwSet)) == $past(hwSet)));
  // R3: read-only bits change only through hardware sets
  assert_ro_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((store ^ $past(store)) & RO_MASK & ~$past(hwSet)) == '0));
  // R6: clear-on-read bits are zero after a read unless set by hardware
  assert_cor_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doRead |=> ((store & COR_MASK & ~$past(hwSet)) == '0));
  // R5: written-one W1C bits are zero after the write unless set by hardware
  assert_w1c_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doWrite |=> ((store & W1C_MASK & $past(wrData) & ~$past(hwSet)) == '0));
endmodule

// File: rtl/bitpol_reg.sv
module bitpol_reg
  import bitpol_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] RESET_VAL      = 16'h0704,
  parameter logic [WIDTH-1:0] RO_MASK        = 16'h000C,
  parameter logic [WIDTH-1:0] W1C_MASK       = 16'h0030,
  parameter logic [WIDTH-1:0] SET_ONLY_MASK  = 16'h00C0,
  parameter logic [WIDTH-1:0] CLR_ONLY_MASK  = 16'h0300,
  parameter logic [WIDTH-1:0] WO_MASK        = 16'h0C00,
  parameter logic [WIDTH-1:0] COR_MASK       = 16'h3000,
  parameter logic [WIDTH-1:0] ERR_ON1_MASK   = 16'h4000,
  parameter logic [WIDTH-1:0] ERR_ON0_MASK   = 16'h8000,
  parameter logic [WIDTH-1:0] UNIMP_ON1_MASK = 16'h0002,
  parameter logic [WIDTH-1:0] UNIMP_ON0_MASK = 16'h0001,
  parameter bit UNDEFINED = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrStb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] wrEn,
  input  logic rdStb,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] hwSet,
  output logic [WIDTH-1:0] regValue,
  output logic errPulse,
  output logic unimpPulse
);
  polCtrl_t ctrl;

  bitpol_ctrl #(
    .WIDTH(WIDTH), .ERR_ON1_MASK(ERR_ON1_MASK), .ERR_ON0_MASK(ERR_ON0_MASK),
    .UNIMP_ON1_MASK(UNIMP_ON1_MASK), .UNIMP_ON0_MASK(UNIMP_ON0_MASK),
    .UNDEFINED(UNDEFINED)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .wrData(wrData),
    .ctrl(ctrl), .errPulse(errPulse), .unimpPulse(unimpPulse)
  );

  bitpol_dp #(
    .WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .RO_MASK(RO_MASK), .W1C_MASK(W1C_MASK),
    .SET_ONLY_MASK(SET_ONLY_MASK), .CLR_ONLY_MASK(CLR_ONLY_MASK),
    .WO_MASK(WO_MASK), .COR_MASK(COR_MASK), .UNDEFINED(UNDEFINED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData), .wrEn(wrEn),
    .hwSet(hwSet), .rdData(rdData), .regValue(regValue)
  );
endmodule

// File: tb/bitpol_reg_bench.sv
module bitpol_reg_bench;
  localparam logic [15:0] RST  = 16'h0704, RO = 16'h000C, W1C = 16'h0030;
  localparam logic [15:0] SO   = 16'h00C0, CO = 16'h0300, WO = 16'h0C00, COR = 16'h3000;
  localparam logic [15:0] E1   = 16'h4000, E0 = 16'h8000, U1 = 16'h0002, U0 = 16'h0001;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrStb = 1'b0, rdStb = 1'b0;
  logic [15:0] wrData = '0, wrEn = '1, hwSet = '0;
  logic [15:0] rdData, regValue, uRd, uVal;
  logic errPulse, unimpPulse, uErr, uUnimp;
  logic [15:0] model;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  bitpol_reg u_bitpol_reg (.clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData),
    .wrEn(wrEn), .rdStb(rdStb), .rdData(rdData), .hwSet(hwSet), .regValue(regValue),
    .errPulse(errPulse), .unimpPulse(unimpPulse));

  bitpol_reg #(.UNDEFINED(1'b1)) u_undef (.clk(clk), .rstN(rstN), .wrStb(wrStb),
    .wrData(wrData), .wrEn(wrEn), .rdStb(rdStb), .rdData(uRd), .hwSet(hwSet),
    .regValue(uVal), .errPulse(uErr), .unimpPulse(uUnimp));

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected read value from the stated policy: write-only bits show reset
  function automatic logic [15:0] readView(input logic [15:0] s);
    for (int i = 0; i < 16; i++) readView[i] = WO[i] ? RST[i] : s[i];
  endfunction

  // expected next stored value, bit by bit from the requirements
  function automatic logic [15:0] nextOf(input logic [15:0] s, input logic w, input logic [15:0] d,
                                         input logic [15:0] e, input logic r, input logic [15:0] h);
    for (int i = 0; i < 16; i++) begin
      logic v;
      v = s[i];
      if (w) begin
        if (e[i] && !RO[i] && !W1C[i]) begin
          if (d[i] && !CO[i]) v = 1'b1;
          if (!d[i] && !SO[i]) v = 1'b0;
        end
        if (W1C[i] && d[i]) v = 1'b0;
      end
      if (r && COR[i]) v = 1'b0;
      if (h[i]) v = 1'b1;
      nextOf[i] = v;
    end
  endfunction

  task automatic step(input string req, input logic w, input logic [15:0] d, input logic [15:0] e,
                      input logic r, input logic [15:0] h);
    logic [15:0] expNext;
    logic expErr, expUn;
    @(negedge clk);
    wrStb = w; wrData = d; wrEn = e; rdStb = r; hwSet = h;
    #1;
    if (r) begin
      chk(req, "rdData before edge", rdData, readView(model));
      chk("R11", "undefined rdData", uRd, 16'h0000);
    end
    expNext = nextOf(model, w, d, e, r, h);
    expErr  = w && (((d & E1) != 0) || ((~d & E0) != 0));
    expUn   = w && (((d & U1) != 0) || ((~d & U0) != 0));
    @(negedge clk);
    model = expNext;
    chk(req, "regValue", regValue, model);
    chk(req, "errPulse", {15'd0, errPulse}, {15'd0, expErr});
    chk(req, "unimpPulse", {15'd0, unimpPulse}, {15'd0, expUn});
    chk("R11", "undefined errPulse", {15'd0, uErr}, {15'd0, w | r});
    chk("R11", "undefined regValue", uVal, RST);
    wrStb = 0; rdStb = 0; hwSet = '0; wrEn = '1;
    @(negedge clk);
    chk(req, "errPulse one cycle", {15'd0, errPulse}, 16'd0);
    chk(req, "unimpPulse one cycle", {15'd0, unimpPulse}, 16'd0);
    chk(req, "idle hold", regValue, model);
  endtask

  task automatic test_reset_R1();
    chk("R1", "regValue", regValue, RST);
    chk("R1", "rdData", rdData, RST);
    chk("R1", "flags", {14'd0, errPulse, unimpPulse}, 16'd0);
  endtask

  task automatic test_enable_R2();
    step("R2", 1, 16'hFFFF, 16'h0003, 0, '0);
    chk("R2", "bits 1:0 set only", regValue & 16'h00C3, 16'h0003);
    step("R2", 1, 16'h8000, 16'h0000, 0, '0);
    chk("R2", "masked-off clear", regValue & 16'h0003, 16'h0003);
  endtask

  task automatic test_readonly_R3();
    step("R3", 1, 16'h8008, 16'hFFFF, 0, '0);
    chk("R3", "ro bits", regValue & RO, 16'h0004);
  endtask

  task automatic test_sticky_R4();
    step("R4", 1, 16'h80C0, 16'h00C0, 0, '0);
    chk("R4", "set-only set", regValue & SO, SO);
    step("R4", 1, 16'h8000, 16'h03C0, 0, '0);
    chk("R4", "set-only not cleared, clear-only cleared", regValue & (SO | CO), SO);
    step("R4", 1, 16'h8300, 16'h0300, 0, '0);
    chk("R4", "clear-only not set", regValue & CO, 16'h0000);
  endtask

  task automatic test_w1c_R5();
    step("R5", 0, '0, '1, 0, 16'h0030);
    step("R5", 1, 16'h8010, 16'hFFFF, 0, '0);
    chk("R5", "bit4 cleared, bit5 kept", regValue & W1C, 16'h0020);
    step("R5", 1, 16'h8020, 16'h0000, 0, '0);
    chk("R5", "clear ignores enable", regValue & W1C, 16'h0000);
  endtask

  task automatic test_cor_R6();
    step("R6", 0, '0, '1, 0, 16'h3000);
    step("R6", 0, '0, '1, 1, '0);
    chk("R6", "cor cleared", regValue & COR, 16'h0000);
  endtask

  task automatic test_wo_R7();
    step("R7", 1, 16'h8800, 16'hFFFF, 0, '0);
    chk("R7", "stored", regValue & WO, 16'h0800);
    chk("R7", "read view", rdData & WO, 16'h0400);
    step("R7", 0, '0, '1, 1, '0);
  endtask

  task automatic test_hwset_R8();
    step("R8", 1, 16'h8010, 16'hFFFF, 0, 16'h0010);
    chk("R8", "set beats w1c", regValue & 16'h0010, 16'h0010);
    step("R8", 0, '0, '1, 1, 16'h1000);
    chk("R8", "set beats cor", regValue & COR, 16'h1000);
    step("R8", 0, '0, '1, 0, 16'h0008);
    chk("R8", "set on ro bit", regValue & RO, 16'h000C);
  endtask

  task automatic test_err_R9();
    step("R9", 1, 16'hC003, 16'hFFFF, 0, '0);
    chk("R9", "write applied", regValue & 16'hC000, 16'hC000);
    step("R9", 1, 16'h0003, 16'hFFFF, 0, '0);
    step("R9", 1, 16'h8003, 16'hFFFF, 0, '0);
  endtask

  task automatic test_unimp_R10();
    step("R10", 1, 16'h8002, 16'h0003, 0, '0);
    step("R10", 1, 16'h8000, 16'h0003, 0, '0);
    chk("R10", "write applied", regValue & 16'h0003, 16'h0000);
    step("R10", 1, 16'h8001, 16'h0003, 0, '0);
  endtask

  task automatic test_undef_R11();
    step("R11", 1, 16'hFFFF, 16'hFFFF, 0, '0);
    step("R11", 0, '0, '1, 1, '0);
    step("R11", 1, 16'h0000, 16'hFFFF, 1, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model = RST;
    repeat (3) @(posedge clk);
    @(negedge clk);
    test_reset_R1();
    rstN = 1'b1;
    @(negedge clk);
    test_reset_R1();
    test_enable_R2();
    test_readonly_R3();
    test_sticky_R4();
    test_w1c_R5();
    test_cor_R6();
    test_wo_R7();
    test_hwset_R8();
    test_err_R9();
    test_unimp_R10();
    test_undef_R11();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule